// File: doc/BRIEF.md
# Lookup-Ratio Serial Clock Generator

This block derives a serial-interface clock from the peripheral clock it runs on. A small index input picks the divide ratio from a fixed ladder. The ladder interleaves powers of two with one-and-a-half times powers of two, from 3 up to 1024. The ratio is chosen once per clock period. Alongside the clock level, the block emits one-cycle strobes that mark the edge leaving the rest level and the edge returning to it. A neighbouring shift engine uses these strobes to launch and capture data without looking at the clock line itself.

The index is computed elsewhere from a target rate: it is the smallest ladder entry whose output does not run faster than the request. Index zero is reserved. The divide-by-3 entry is usable only while a dedicated permit input is high. Any index above the top of the ladder is clamped to the top entry. A parameter sets the top of the ladder to 16 or to 18. Because the ratio can be odd, the two halves of a period can differ by one input cycle.

Top module: `spi_clkdiv`

## Requirements
- R1: For an effective index k, the period between successive leading edges is N input cycles. Index 1 gives N=3 and index 2 gives N=4. Beyond that, an even k gives N = 2^(k/2+1) and an odd k gives N = 3*2^((k-1)/2), so index 18 gives 1024.
- R2: In each period the clock stays away from its rest level for floor(N/2) cycles and at its rest level for ceil(N/2) cycles. For N=3 this is 1 cycle away and 2 cycles at rest.
- R3: While no period is running, `sclk_o` equals `cpol_i`. The first leading edge comes ceil(N/2) cycles after the clock edge that samples `en_i` high with a usable index.
- R4: Index 0 never starts a period. `sclk_o` stays at the rest level, no strobe appears, and `cfg_err_o` is 1 from the cycle after the index is presented.
- R5: Index 1 starts periods of N=3 only while `div3_en_i` is 1. With `div3_en_i` at 0 it behaves as in R4.
- R6: An index above the top of the ladder (18 with `WIDE_LADDER`=1, 16 otherwise) acts as the top index. With the default parameters, indices 25 and 31 both give N=1024.
- R7: A new index is sampled only on the edge that starts a period: the enabling edge or a trailing edge. A change during a period leaves that period's timing untouched.
- R8: `lead_o` is high for exactly the first cycle in which `sclk_o` is away from rest. `trail_o` is high for exactly the first cycle in which `sclk_o` is back at rest. The two are never high together.
- R9: If `en_i` is low in the rest half, the block stops with no further edge. If `en_i` is low in the away half, that half completes with its trailing edge and then the block stops.
- R10: `cfg_err_o` is 0 after reset and 0 one cycle after a usable index is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run request |
| div_idx_i | input | IDX_W | Ladder index |
| div3_en_i | input | 1 | Permits index 1 (divide-by-3) |
| cpol_i | input | 1 | Rest level of the serial clock |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | One-cycle strobe for the edge away from rest |
| trail_o | output | 1 | One-cycle strobe for the edge back to rest |
| cfg_err_o | output | 1 | Requested index is reserved or not permitted |

## Verification
A trailing edge and the sampling of a new index can fall on the same clock edge. When they do, the period that edge starts must already use the new ratio. The bench provokes this by presenting a different index on the cycle just before a trailing edge. Its scoreboard then expects the following leading edge at the new half-period, measured from that trailing edge. A second collision is exercised the same way: `en_i` dropped during the away half, where the trailing edge must still appear before the block stops.

// File: rtl/spi_clkdiv_pkg.sv
`timescale 1ns/1ps
package spi_clkdiv_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_REST = 2'd1,
      SEQ_AWAY = 2'd2
   } seq_state_e;

   // ladder entry for index k: 0 reserved, odd k -> 3*2^(k>>1), even k -> 2^((k>>1)+1)
   function automatic int unsigned ratio_of_index(input int unsigned k);
      if (k == 0)
         return 0;
      if ((k % 2) == 1)
         return 3 << (k >> 1);
      return 1 << ((k >> 1) + 1);
   endfunction

   function automatic int unsigned ratio_bits(input int unsigned top_idx);
      return $clog2(ratio_of_index(top_idx) + 1);
   endfunction

endpackage

// File: rtl/spi_clkdiv_decode.sv
`timescale 1ns/1ps
module spi_clkdiv_decode
   import spi_clkdiv_pkg::*;
#(
   parameter int unsigned IDX_W       = 5,
   parameter int unsigned MAX_IDX     = 18,
   parameter int unsigned RATIO_W     = 11,
   parameter int unsigned HALF_W      = 10,
   parameter bit          DIV3_GATED  = 1'b1
) (
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              div3_en_i,
   output logic              cfg_ok_o,
   output logic [HALF_W-1:0] rest_len_o,
   output logic [HALF_W-1:0] away_len_o
);

   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(MAX_IDX);

   logic [RATIO_W-1:0] ratio_tbl [MAX_IDX+1];
   logic [IDX_W-1:0]   eff_idx;
   logic [RATIO_W-1:0] ratio;
   logic [RATIO_W:0]   ratio_up;
   logic               idx_nonzero;
   logic               div3_ok;

   // ladder built from the closed form, one constant per entry
   for (genvar g = 0; g <= MAX_IDX; g++) begin : g_ladder
      localparam int unsigned ENTRY = ratio_of_index(g);
      assign ratio_tbl[g] = RATIO_W'(ENTRY);
   end

   // clamp indices beyond the top of the ladder
   assign eff_idx     = (idx_i > TOP_IDX) ? TOP_IDX : idx_i;
   assign ratio       = ratio_tbl[eff_idx];
   assign idx_nonzero = (eff_idx != '0);

   if (DIV3_GATED) begin : g_div3_gated
      assign div3_ok = (eff_idx != IDX_W'(1)) || div3_en_i;
   end else begin : g_div3_free
      logic unused_div3;
      assign unused_div3 = div3_en_i;
      assign div3_ok     = 1'b1;
   end

   assign cfg_ok_o = idx_nonzero && div3_ok;

   // rest half takes the extra cycle of an odd ratio
   assign ratio_up   = {1'b0, ratio} + {{RATIO_W{1'b0}}, 1'b1};
   assign rest_len_o = HALF_W'(ratio_up >> 1);
   assign away_len_o = HALF_W'(ratio >> 1);

   always_comb begin
      AST_USABLE_HAS_HALVES: assert (!cfg_ok_o || ((rest_len_o != '0) && (away_len_o != '0)))
         else $error("usable index decoded to an empty half"); // R1
   end

endmodule

// File: rtl/spi_clkdiv_seq.sv
`timescale 1ns/1ps
module spi_clkdiv_seq
   import spi_clkdiv_pkg::*;
#(
   parameter int unsigned HALF_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              cfg_ok_i,
   input  logic              cpol_i,
   input  logic [HALF_W-1:0] rest_len_i,
   input  logic [HALF_W-1:0] away_len_i,
   output logic              lead_evt_o,
   output logic              trail_evt_o,
   output logic              running_o,
   output logic              cpol_q_o
);

   localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

   seq_state_e        state_q;
   logic [HALF_W-1:0] cnt_q;
   logic [HALF_W-1:0] away_q;
   logic              cpol_q;
   logic              go;
   logic              cnt_zero;
   logic              keep_going;

   assign go         = en_i && cfg_ok_i;
   assign cnt_zero   = (cnt_q == '0);
   assign keep_going = go && (cpol_i == cpol_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
         away_q  <= '0;
         cpol_q  <= 1'b0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (go) begin
                  state_q <= SEQ_REST;
                  cnt_q   <= rest_len_i - ONE;
                  away_q  <= away_len_i;
                  cpol_q  <= cpol_i;
               end
            end
            SEQ_REST: begin
               if (!en_i) begin
                  state_q <= SEQ_IDLE;
               end else if (cnt_zero) begin
                  state_q <= SEQ_AWAY;
                  cnt_q   <= away_q - ONE;
               end else begin
                  cnt_q <= cnt_q - ONE;
               end
            end
            SEQ_AWAY: begin
               if (cnt_zero) begin
                  if (keep_going) begin
                     state_q <= SEQ_REST;
                     cnt_q   <= rest_len_i - ONE;
                     away_q  <= away_len_i;
                  end else begin
                     state_q <= SEQ_IDLE;
                  end
               end else begin
                  cnt_q <= cnt_q - ONE;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign lead_evt_o  = (state_q == SEQ_REST) && en_i && cnt_zero;
   assign trail_evt_o = (state_q == SEQ_AWAY) && cnt_zero;
   assign running_o   = (state_q != SEQ_IDLE);
   assign cpol_q_o    = cpol_q;

   AST_AWAY_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_AWAY) |-> (cnt_q < away_q)); // R2

   AST_AWAY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == SEQ_AWAY) && !cnt_zero) |=> (state_q == SEQ_AWAY)); // R9

endmodule

// File: rtl/spi_clkdiv_edge_out.sv
`timescale 1ns/1ps
module spi_clkdiv_edge_out (
   input  logic clk,
   input  logic rst_n,
   input  logic running_i,
   input  logic lead_evt_i,
   input  logic trail_evt_i,
   input  logic rest_lvl_i,
   output logic sclk_o,
   output logic lead_o,
   output logic trail_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_o  <= 1'b0;
         lead_o  <= 1'b0;
         trail_o <= 1'b0;
      end else begin
         lead_o  <= lead_evt_i;
         trail_o <= trail_evt_i && !lead_evt_i;
         if (lead_evt_i)
            sclk_o <= !rest_lvl_i;
         else if (trail_evt_i || !running_i)
            sclk_o <= rest_lvl_i;
      end
   end

   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_o && trail_o)); // R8

   AST_LEAD_MOVES_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      lead_o |-> (sclk_o != $past(sclk_o))); // R8

   AST_TRAIL_MOVES_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      trail_o |-> (sclk_o != $past(sclk_o))); // R8

endmodule

// File: rtl/spi_clkdiv.sv
`timescale 1ns/1ps
module spi_clkdiv
   import spi_clkdiv_pkg::*;
#(
   parameter int unsigned IDX_W       = 5,
   parameter bit          WIDE_LADDER = 1'b1,
   parameter bit          DIV3_GATED  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [IDX_W-1:0] div_idx_i,
   input  logic             div3_en_i,
   input  logic             cpol_i,
   output logic             sclk_o,
   output logic             lead_o,
   output logic             trail_o,
   output logic             cfg_err_o
);

   localparam int unsigned MAX_IDX = WIDE_LADDER ? 18 : 16;
   localparam int unsigned RATIO_W = ratio_bits(MAX_IDX);
   localparam int unsigned HALF_W  = RATIO_W - 1;

   if (IDX_W < $clog2(MAX_IDX + 1)) begin : g_bad_idx_w
      $error("IDX_W too narrow for the ladder");
   end
   if (RATIO_W < 3) begin : g_bad_ratio_w
      $error("ratio width too small");
   end

   logic              cfg_ok;
   logic [HALF_W-1:0] rest_len;
   logic [HALF_W-1:0] away_len;
   logic              lead_evt;
   logic              trail_evt;
   logic              running;
   logic              cpol_q;
   logic              rest_lvl;

   spi_clkdiv_decode #(
      .IDX_W      (IDX_W),
      .MAX_IDX    (MAX_IDX),
      .RATIO_W    (RATIO_W),
      .HALF_W     (HALF_W),
      .DIV3_GATED (DIV3_GATED)
   ) u_decode (
      .idx_i      (div_idx_i),
      .div3_en_i  (div3_en_i),
      .cfg_ok_o   (cfg_ok),
      .rest_len_o (rest_len),
      .away_len_o (away_len)
   );

   spi_clkdiv_seq #(
      .HALF_W (HALF_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (en_i),
      .cfg_ok_i    (cfg_ok),
      .cpol_i      (cpol_i),
      .rest_len_i  (rest_len),
      .away_len_i  (away_len),
      .lead_evt_o  (lead_evt),
      .trail_evt_o (trail_evt),
      .running_o   (running),
      .cpol_q_o    (cpol_q)
   );

   // rest level follows the pin while idle, the latched value while running
   assign rest_lvl = running ? cpol_q : cpol_i;

   spi_clkdiv_edge_out u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .running_i   (running),
      .lead_evt_i  (lead_evt),
      .trail_evt_i (trail_evt),
      .rest_lvl_i  (rest_lvl),
      .sclk_o      (sclk_o),
      .lead_o      (lead_o),
      .trail_o     (trail_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_err_o <= 1'b0;
      else
         cfg_err_o <= !cfg_ok;
   end

   AST_IDLE_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !$past(running)) |-> (sclk_o == $past(cpol_i))); // R3

   AST_BAD_IDX_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !cfg_ok) |=> !running); // R4

   AST_ERR_MEANS_NO_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err_o && !running) |-> !lead_o); // R5

endmodule

// File: tb/spi_clkdiv_tb_top.sv
`timescale 1ns/1ps
module spi_clkdiv_tb_top;

   typedef enum bit {EV_LEAD = 1'b0, EV_TRAIL = 1'b1} ev_e;
   typedef struct {
      int    cyc;
      ev_e   kind;
      bit    lvl;
      string tag;
   } exp_t;

   localparam int WD_LIMIT = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [4:0] idx = 5'd2;
   logic       div3_en = 1'b0;
   logic       cpol = 1'b0;
   logic       sclk, lead, trail, cfg_err;

   int   cyc = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   exp_t exp_q[$];

   int ladder [19] = '{0, 3, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192, 256, 384, 512, 768, 1024};

   spi_clkdiv dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (en),
      .div_idx_i (idx),
      .div3_en_i (div3_en),
      .cpol_i    (cpol),
      .sclk_o    (sclk),
      .lead_o    (lead),
      .trail_o   (trail),
      .cfg_err_o (cfg_err)
   );

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic push(input int c, input ev_e k, input bit l, input string tag);
      exp_t e;
      e.cyc = c; e.kind = k; e.lvl = l; e.tag = tag;
      exp_q.push_back(e);
   endtask

   function automatic int period_of(input int k);
      int e = (k > 18) ? 18 : k;
      return ladder[e];
   endfunction

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   // monitor: every strobe must match the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
            chk(1'b0, {exp_q[0].tag, " missed edge"}, 0, exp_q[0].cyc);
            void'(exp_q.pop_front());
         end
         if (lead || trail) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 unexpected strobe", cyc, -1);
            end else begin
               chk(exp_q[0].cyc == cyc, {exp_q[0].tag, " edge cycle"}, cyc, exp_q[0].cyc);
               if (exp_q[0].cyc == cyc) begin
                  chk((lead ? EV_LEAD : EV_TRAIL) == exp_q[0].kind, {exp_q[0].tag, " edge kind"},
                      int'(trail), int'(exp_q[0].kind));
                  chk(sclk == exp_q[0].lvl, "R8 clock level at strobe", int'(sclk), int'(exp_q[0].lvl));
                  void'(exp_q.pop_front());
               end
            end
         end
      end
   end

   // driver: start a run, queue the expected strobes, stop after the last trailing edge
   task automatic burst(input int k, input bit pol, input bit permit, input int periods, input string tag);
      int kk, n, c, last;
      @(negedge clk);
      idx = 5'(k); cpol = pol; div3_en = permit; en = 1'b1;
      kk = cyc;
      n = period_of(k);
      c = (n + 1) / 2;
      for (int p = 0; p < periods; p++) begin
         push(kk + 1 + p * n + c, EV_LEAD, !pol, tag);
         push(kk + 1 + (p + 1) * n, EV_TRAIL, pol, tag);
      end
      last = kk + 1 + periods * n;
      wait_until(last);
      en = 1'b0;
      repeat (3) @(negedge clk);
      chk(sclk == pol, "R3 rest level after run", int'(sclk), int'(pol));
   endtask

   task automatic refused(input int k, input bit permit, input string tag);
      @(negedge clk);
      idx = 5'(k); div3_en = permit; en = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(cfg_err == 1'b1, {tag, " error flag"}, int'(cfg_err), 1);
      for (int i = 0; i < 4; i++) begin
         repeat (10) @(negedge clk);
         chk(sclk == cpol, {tag, " clock held at rest"}, int'(sclk), int'(cpol));
      end
      en = 1'b0; idx = 5'd2;
      @(negedge clk); @(negedge clk);
      chk(cfg_err == 1'b0, "R10 error clears", int'(cfg_err), 0);
   endtask

   initial begin : watchdog
      wait (cyc == WD_LIMIT);
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : driver
      int kk;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sclk == 1'b0, "R3 reset clock level", int'(sclk), 0);
      chk(!lead && !trail, "R8 reset strobes", int'(lead) + int'(trail), 0);
      chk(cfg_err == 1'b0, "R10 reset error flag", int'(cfg_err), 0);

      burst(2, 1'b0, 1'b0, 3, "R1 div4");
      burst(3, 1'b0, 1'b0, 2, "R2 div6");
      burst(5, 1'b0, 1'b0, 2, "R1 div12");
      burst(1, 1'b0, 1'b1, 4, "R5 div3 permitted");
      burst(7, 1'b0, 1'b0, 1, "R2 div24");
      burst(4, 1'b1, 1'b0, 3, "R3 high rest level");
      burst(18, 1'b0, 1'b0, 2, "R1 div1024");
      burst(25, 1'b0, 1'b0, 1, "R6 clamp 25");
      burst(31, 1'b1, 1'b0, 1, "R6 clamp 31");
      @(negedge clk);
      chk(cfg_err == 1'b0, "R10 usable index no error", int'(cfg_err), 0);

      cpol = 1'b0;
      refused(0, 1'b1, "R4 reserved index");
      refused(1, 1'b0, "R5 div3 not permitted");

      // R7: new index sampled on the trailing edge itself
      @(negedge clk);
      idx = 5'd2; cpol = 1'b0; div3_en = 1'b0; en = 1'b1;
      kk = cyc;
      push(kk + 3, EV_LEAD, 1'b1, "R7 old ratio");
      push(kk + 5, EV_TRAIL, 1'b0, "R7 old ratio");
      push(kk + 8, EV_LEAD, 1'b1, "R7 new ratio");
      push(kk + 11, EV_TRAIL, 1'b0, "R7 new ratio");
      push(kk + 14, EV_LEAD, 1'b1, "R7 new ratio");
      push(kk + 17, EV_TRAIL, 1'b0, "R7 new ratio");
      wait_until(kk + 4);
      idx = 5'd3;
      wait_until(kk + 17);
      en = 1'b0;
      repeat (12) @(negedge clk);

      // R9: enable dropped in the rest half, no edge at all
      @(negedge clk);
      idx = 5'd6; en = 1'b1;
      kk = cyc;
      wait_until(kk + 3);
      en = 1'b0;
      repeat (20) @(negedge clk);
      chk(sclk == 1'b0, "R9 stop in rest half", int'(sclk), 0);

      // R9: enable dropped in the away half, trailing edge still comes
      @(negedge clk);
      idx = 5'd4; en = 1'b1;
      kk = cyc;
      push(kk + 5, EV_LEAD, 1'b1, "R9 away half");
      push(kk + 9, EV_TRAIL, 1'b0, "R9 away half completes");
      wait_until(kk + 5);
      en = 1'b0;
      repeat (20) @(negedge clk);
      chk(sclk == 1'b0, "R9 rest after stop", int'(sclk), 0);

      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R8 all expected edges seen", exp_q.size(), 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule